// File: doc/BRIEF.md
# Oversampling Serial Receiver with Idle-Line Flag

This block receives asynchronous serial frames on a single input line. Each frame has a low start bit, 8 or 9 data bits sent least significant first, and a high stop bit. A fractional divisor sets the rate of an internal sample tick that runs at sixteen times the bit rate. The divisor has a 12-bit integer part and a 4-bit fraction, so one bit lasts exactly `div_i` clock cycles on average. Every bit is decided by a vote of three samples taken around its middle.

A finished word moves from the shift register into a separate holding register, which a consumer reads with a one-cycle strobe. The status flags show when a word is ready, when a word was lost because the holding register was still full, when the samples of a bit disagreed, and when a stop bit was sampled low. A further flag reports that the line has stayed high for a whole frame length after the last received frame. Software uses it to detect the end of a burst.

Top module: `uart_os_rx`

## Requirements
- R1: A frame is a low start bit, then 8 data bits (`wlen9_i`=0) or 9 data bits (`wlen9_i`=1) sent LSB first, then a stop bit. In 8-bit mode `data_o[8]` is 0 and `data_o[7:0]` holds the word.
- R2: The sample tick runs at 16 times the bit rate, so one bit lasts `div_i` clock cycles. `div_i[15:4]` is the integer part and `div_i[3:0]` the sixteenths. Any `div_i` below 16 acts as 16, which gives one tick per clock and a 16-clock bit.
- R3: After a falling edge, a start bit is accepted only if the majority of its samples 7, 8 and 9 are low. Otherwise the receiver goes back to hunting and delivers no word.
- R4: Every bit is the majority of its samples 7, 8 and 9. If those three samples disagree in any bit of a frame, `noise_o` is set together with that frame's word.
- R5: A stop bit sampled low sets `ferr_o`. The word is still delivered and `ready_o` is set.
- R6: When a frame completes with `ready_o` low, the word is loaded into `data_o` and `ready_o` goes high on the next cycle.
- R7: When a frame completes while `ready_o` is still high, `ovr_o` is set. `data_o`, `noise_o` and `ferr_o` keep their old values.
- R8: A one-cycle pulse on `rd_i` clears `ready_o`, `ovr_o`, `noise_o`, `ferr_o` and `idle_o` on the next cycle.
- R9: `idle_o` is set once the line has been sampled high for a full frame length, 16×(word bits+2) ticks, counted from the end of the last frame. It is set only if a frame has been received since reset, and only once until the next frame arrives.
- R10: While `en_i` is low, the receiver stays in hunting and ignores the line. The word and flags already held are kept.
- R11: After reset, `data_o` is 0 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idles high |
| en_i | input | 1 | Receiver enable |
| wlen9_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| div_i | input | 16 | Rate divisor in 12.4 fixed point |
| rd_i | input | 1 | Read strobe for the holding register |
| data_o | output | 9 | Received word |
| ready_o | output | 1 | A word is waiting to be read |
| ovr_o | output | 1 | A word was lost because the holding register was full |
| noise_o | output | 1 | The samples of a bit disagreed in the held word |
| ferr_o | output | 1 | The held word had a low stop bit |
| idle_o | output | 1 | The line went idle after a frame |

## Verification
On every cycle the assertions check how a completed frame updates the holding register and its flags. This covers loading a word into an empty register, holding the old word and flags on overrun, clearing on a read strobe, and the idle event raising its flag. They also check that the frame state machine only moves on a sample tick. Only the bench scenarios can show the serial-level behaviour, because it depends on the line timing: the bit order for both word lengths, the fractional bit period, and rejection of a short start pulse. The same holds for the vote against a one-sample glitch, the idle window measured in bit times, and the enable gating.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  // two-of-three vote on the mid-bit samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // true when the three samples are not all equal
  function automatic logic split3(input logic a, input logic b, input logic c);
    return (a != b) || (b != c);
  endfunction

  // ticks in one frame: start + data + stop
  function automatic int unsigned frame_ticks(input int unsigned osr, input int unsigned bits);
    return osr * (bits + 2);
  endfunction

endpackage

// File: rtl/rxo_sync.sv
module rxo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rxo_tick.sv
module rxo_tick #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int ACC_W = DIV_W + 1;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << FRAC_W;

  // divisor floor: one tick per clock at most
  function automatic logic [ACC_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    logic [ACC_W-1:0] w;
    w = {1'b0, d};
    return (w < STEP) ? STEP : w;
  endfunction

  logic [ACC_W-1:0] acc, nxt, lim;

  always_comb begin
    lim = eff_div(div_i);
    nxt = acc + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      acc    <= '0;
      tick_o <= 1'b0;
    end else if (nxt >= lim) begin
      acc    <= nxt - lim;
      tick_o <= 1'b1;
    end else begin
      acc    <= nxt;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rxo_frame.sv
module rxo_frame
  import rxo_pkg::*;
#(
  parameter int OSR  = 16,
  parameter int WMAX = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic            rx_i,
  input  logic            nine_i,
  output logic            done_o,
  output logic [WMAX-1:0] word_o,
  output logic            ferr_o,
  output logic            noise_o,
  output rx_state_e       state_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(WMAX);
  localparam logic [CNT_W-1:0] S_LO  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] S_MID = CNT_W'(OSR/2);
  localparam logic [CNT_W-1:0] S_HI  = CNT_W'(OSR/2 + 1);
  localparam logic [CNT_W-1:0] S_END = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(WMAX - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(WMAX - 2);

  rx_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [WMAX-1:0]  sh;
  logic             s_lo, s_mid, nine, noisy;
  logic             vote, split;
  logic [IDX_W-1:0] last_idx;

  always_comb begin
    vote     = vote3(s_lo, s_mid, rx_i);
    split    = split3(s_lo, s_mid, rx_i);
    last_idx = nine ? LAST_LONG : LAST_SHORT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_HUNT;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      s_lo    <= 1'b1;
      s_mid   <= 1'b1;
      nine    <= 1'b0;
      noisy   <= 1'b0;
      done_o  <= 1'b0;
      word_o  <= '0;
      ferr_o  <= 1'b0;
      noise_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        st  <= ST_HUNT;
        cnt <= '0;
      end else if (tick_i) begin
        if (st == ST_HUNT) begin
          if (!rx_i) begin
            st    <= ST_START;
            cnt   <= CNT_W'(1);
            noisy <= 1'b0;
            nine  <= nine_i;
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == S_LO)  s_lo  <= rx_i;
          if (cnt == S_MID) s_mid <= rx_i;
          if (cnt == S_HI) begin
            unique case (st)
              ST_START: begin
                if (vote) st <= ST_HUNT;
                else      noisy <= noisy | split;
              end
              ST_DATA: begin
                sh    <= {vote, sh[WMAX-1:1]};
                noisy <= noisy | split;
              end
              ST_STOP: begin
                st      <= ST_HUNT;
                done_o  <= 1'b1;
                ferr_o  <= ~vote;
                noise_o <= noisy | split;
                word_o  <= nine ? sh : {1'b0, sh[WMAX-1:1]};
              end
              default: st <= ST_HUNT;
            endcase
          end
          if (cnt == S_END) begin
            if (st == ST_START) begin
              st  <= ST_DATA;
              idx <= '0;
            end else if (st == ST_DATA) begin
              if (idx == last_idx) st <= ST_STOP;
              else                 idx <= idx + 1'b1;
            end
          end
        end
      end
    end
  end

  assign state_o = st;
endmodule

// File: rtl/rxo_idle.sv
module rxo_idle
  import rxo_pkg::*;
#(
  parameter int OSR  = 16,
  parameter int WMAX = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic hunt_i,
  input  logic rx_i,
  input  logic nine_i,
  input  logic frame_done_i,
  output logic idle_hit_o
);
  localparam int LIM_MAX = frame_ticks(OSR, WMAX);
  localparam int CW      = $clog2(LIM_MAX + 1);

  logic [CW-1:0] run, lim;
  logic          armed;

  always_comb lim = CW'(frame_ticks(OSR, nine_i ? WMAX : WMAX - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= '0;
      armed      <= 1'b0;
      idle_hit_o <= 1'b0;
    end else begin
      idle_hit_o <= 1'b0;
      if (frame_done_i) begin
        armed <= 1'b1;
        run   <= '0;
      end else if (!en_i || !hunt_i || !rx_i) begin
        run <= '0;
      end else if (tick_i && armed) begin
        if (run == lim - 1'b1) begin
          idle_hit_o <= 1'b1;
          armed      <= 1'b0;
          run        <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import rxo_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4,
  parameter int OSR    = 16,
  parameter int WMAX   = 9,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             en_i,
  input  logic             wlen9_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rd_i,
  output logic [WMAX-1:0]  data_o,
  output logic             ready_o,
  output logic             ovr_o,
  output logic             noise_o,
  output logic             ferr_o,
  output logic             idle_o
);
  logic            rx_s;
  logic            os_tick;
  logic            frame_done;
  logic [WMAX-1:0] frame_word;
  logic            frame_ferr, frame_noise;
  logic            idle_hit;
  rx_state_e       rx_state;
  logic            hunting;

  rxo_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
  );

  rxo_tick #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .div_i(div_i), .tick_o(os_tick)
  );

  rxo_frame #(.OSR(OSR), .WMAX(WMAX)) u_frame (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(os_tick), .rx_i(rx_s),
    .nine_i(wlen9_i), .done_o(frame_done), .word_o(frame_word),
    .ferr_o(frame_ferr), .noise_o(frame_noise), .state_o(rx_state)
  );

  assign hunting = (rx_state == ST_HUNT);

  rxo_idle #(.OSR(OSR), .WMAX(WMAX)) u_idle (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(os_tick), .hunt_i(hunting),
    .rx_i(rx_s), .nine_i(wlen9_i), .frame_done_i(frame_done),
    .idle_hit_o(idle_hit)
  );

  // holding register and status flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      ready_o <= 1'b0;
      ovr_o   <= 1'b0;
      noise_o <= 1'b0;
      ferr_o  <= 1'b0;
      idle_o  <= 1'b0;
    end else begin
      if (rd_i) begin
        ready_o <= 1'b0;
        ovr_o   <= 1'b0;
        noise_o <= 1'b0;
        ferr_o  <= 1'b0;
        idle_o  <= 1'b0;
      end
      if (frame_done) begin
        if (ready_o && !rd_i) begin
          ovr_o <= 1'b1;
        end else begin
          data_o  <= frame_word;
          ready_o <= 1'b1;
          noise_o <= frame_noise;
          ferr_o  <= frame_ferr;
        end
      end
      if (idle_hit) idle_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rxo_chk.sv
module rxo_chk
  import rxo_pkg::*;
#(
  parameter int WMAX = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_i,
  input logic            rd_i,
  input logic [WMAX-1:0] data_o,
  input logic            ready_o,
  input logic            ovr_o,
  input logic            ferr_o,
  input logic            idle_o,
  input logic            frame_done,
  input logic [WMAX-1:0] frame_word,
  input logic            frame_ferr,
  input logic            idle_hit,
  input logic            os_tick,
  input rx_state_e       rx_state
);
  // R6: a word completing into an empty register is loaded and flagged
  p_load_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !ready_o |=> ready_o && data_o == $past(frame_word));

  // R5: the stop-bit result travels with the loaded word
  p_ferr_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !ready_o |=> ferr_o == $past(frame_ferr));

  // R7: an overrun keeps the held word and raises the overrun flag
  p_overrun_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && ready_o && !rd_i |=> ovr_o && $stable(data_o) && $stable(ferr_o));

  // R8: a read with no competing event empties the flags
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i && !frame_done && !idle_hit |=> !ready_o && !ovr_o && !idle_o && !ferr_o);

  // R9: an idle event always shows up on the flag
  p_idle_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> idle_o);

  // R2: the frame state advances only on a sample tick
  p_state_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !os_tick |=> $stable(rx_state));
endmodule

bind uart_os_rx rxo_chk #(.WMAX(WMAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .rd_i(rd_i), .data_o(data_o),
  .ready_o(ready_o), .ovr_o(ovr_o), .ferr_o(ferr_o), .idle_o(idle_o),
  .frame_done(frame_done), .frame_word(frame_word), .frame_ferr(frame_ferr),
  .idle_hit(idle_hit), .os_tick(os_tick), .rx_state(rx_state)
);

// File: tb/tb_uart_os_rx.sv
`timescale 1ns/1ps
module tb_uart_os_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_i = 1'b1;
  logic        en_i = 1'b0;
  logic        wlen9_i = 1'b0;
  logic [15:0] div_i = 16'd160;
  logic        rd_i = 1'b0;
  logic [8:0]  data_o;
  logic        ready_o, ovr_o, noise_o, ferr_o, idle_o;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;
  int bitclk = 160;

  always #2.5 clk = ~clk;

  uart_os_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .en_i(en_i), .wlen9_i(wlen9_i),
    .div_i(div_i), .rd_i(rd_i), .data_o(data_o), .ready_o(ready_o),
    .ovr_o(ovr_o), .noise_o(noise_o), .ferr_o(ferr_o), .idle_o(idle_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // expected word as seen at data_o
  function automatic logic [8:0] exp_word(input logic [8:0] w, input bit nine);
    return nine ? w : {1'b0, w[7:0]};
  endfunction

  // frame length in clocks for the idle window
  function automatic int idle_clocks(input bit nine, input int per);
    return (nine ? 11 : 10) * per;
  endfunction

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  // glitch_bit < 0: clean frame; otherwise invert the line for one tick at mid-bit
  task automatic send(input logic [8:0] w, input bit nine, input bit stop_v, input int glitch_bit);
    int nb;
    nb = nine ? 9 : 8;
    rx_i = 1'b0;
    hold(bitclk);
    for (int i = 0; i < nb; i++) begin
      rx_i = w[i];
      if (i == glitch_bit) begin
        hold(bitclk / 2);
        rx_i = ~w[i];
        hold(bitclk / 16);
        rx_i = w[i];
        hold(bitclk - bitclk / 2 - bitclk / 16);
      end else begin
        hold(bitclk);
      end
    end
    rx_i = stop_v;
    hold(bitclk);
    rx_i = 1'b1;
  endtask

  task automatic do_read();
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic set_rate(input int d, input int per, input bit nine);
    en_i = 1'b0;
    hold(2);
    div_i = 16'(d);
    bitclk = per;
    wlen9_i = nine;
    en_i = 1'b1;
    hold(2 * per);
  endtask

  task automatic plain_frames(input int n, input bit nine, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [8:0] w;
      w = 9'($urandom);
      send(w, nine, 1'b1, -1);
      chk(ready_o === 1'b1, {tag, " ready"}, 32'(ready_o), 1);
      chk(data_o === exp_word(w, nine), {tag, " word"}, 32'(data_o), 32'(exp_word(w, nine)));
      chk(ferr_o === 1'b0 && noise_o === 1'b0, {tag, " clean flags"}, {30'd0, ferr_o, noise_o}, 0);
      do_read();
    end
  endtask

  initial begin
    logic [8:0] w1, w2;
    int sd;
    sd = $urandom(32'd2024);
    hold(5);
    // R11 reset state
    chk(data_o === 9'd0, "R11 data after reset", 32'(data_o), 0);
    chk({ready_o, ovr_o, noise_o, ferr_o, idle_o} === 5'd0, "R11 flags after reset",
        32'({ready_o, ovr_o, noise_o, ferr_o, idle_o}), 0);
    rst_n = 1'b1;
    hold(2);
    en_i = 1'b1;
    hold(2 * bitclk);

    // R1 R6 8-bit words, integer divisor
    plain_frames(6, 1'b0, "R1/R6 8-bit");
    chk(ready_o === 1'b0, "R8 read empties ready", 32'(ready_o), 0);

    // R1 R2 9-bit words with fractional divisors
    set_rate(168, 168, 1'b1);
    plain_frames(5, 1'b1, "R2 9-bit div 10.5");
    set_rate(167, 167, 1'b1);
    plain_frames(3, 1'b1, "R2 9-bit div 10.4375");
    // R2 floor: divisor below 16 behaves as 16
    set_rate(5, 16, 1'b0);
    plain_frames(3, 1'b0, "R2 small divisor");

    // R3 short low pulse is rejected
    set_rate(160, 160, 1'b0);
    rx_i = 1'b0;
    hold(40);
    rx_i = 1'b1;
    hold(20 * bitclk);
    chk(ready_o === 1'b0, "R3 short pulse gives no word", 32'(ready_o), 0);
    plain_frames(1, 1'b0, "R3 recovery");

    // R4 single-tick glitch is voted out and flagged
    for (int k = 0; k < 4; k++) begin
      int gb;
      w1 = 9'($urandom);
      gb = k == 0 ? 0 : int'($urandom % 8);
      send(w1, 1'b0, 1'b1, gb);
      chk(data_o === exp_word(w1, 1'b0), "R4 glitched word", 32'(data_o), 32'(exp_word(w1, 1'b0)));
      chk(noise_o === 1'b1, "R4 noise flag", 32'(noise_o), 1);
      do_read();
      chk(noise_o === 1'b0, "R8 read clears noise", 32'(noise_o), 0);
    end

    // R5 low stop bit
    w1 = 9'h0C3;
    send(w1, 1'b0, 1'b0, -1);
    chk(ready_o === 1'b1, "R5 word delivered despite low stop", 32'(ready_o), 1);
    chk(data_o === exp_word(w1, 1'b0), "R5 word", 32'(data_o), 32'(exp_word(w1, 1'b0)));
    chk(ferr_o === 1'b1, "R5 framing flag", 32'(ferr_o), 1);
    do_read();
    chk(ferr_o === 1'b0, "R8 read clears framing flag", 32'(ferr_o), 0);
    hold(20 * bitclk);
    chk(ready_o === 1'b0, "R3 no word after low stop", 32'(ready_o), 0);

    // R7 overrun
    w1 = 9'($urandom);
    w2 = ~w1;
    send(w1, 1'b0, 1'b1, -1);
    send(w2, 1'b0, 1'b0, -1);
    chk(ovr_o === 1'b1, "R7 overrun flag", 32'(ovr_o), 1);
    chk(data_o === exp_word(w1, 1'b0), "R7 old word kept", 32'(data_o), 32'(exp_word(w1, 1'b0)));
    chk(ferr_o === 1'b0, "R7 old framing flag kept", 32'(ferr_o), 0);
    do_read();
    chk(ovr_o === 1'b0 && ready_o === 1'b0, "R8 read clears overrun", {30'd0, ovr_o, ready_o}, 0);
    hold(20 * bitclk);

    // R9 idle flag, both word lengths
    for (int m = 0; m < 2; m++) begin
      bit nine;
      nine = (m == 1);
      set_rate(160, 160, nine);
      rst_n = 1'b0;
      hold(3);
      rst_n = 1'b1;
      hold(idle_clocks(nine, bitclk) * 2);
      chk(idle_o === 1'b0, "R9 no idle before any frame", 32'(idle_o), 0);
      w1 = 9'($urandom);
      send(w1, nine, 1'b1, -1);
      do_read();
      hold(idle_clocks(nine, bitclk) - 12 * bitclk / 16 - 2);
      chk(idle_o === 1'b0, "R9 idle not before a frame length", 32'(idle_o), 0);
      hold(14 * bitclk / 16);
      chk(idle_o === 1'b1, "R9 idle after a frame length", 32'(idle_o), 1);
      do_read();
      chk(idle_o === 1'b0, "R8 read clears idle", 32'(idle_o), 0);
      hold(idle_clocks(nine, bitclk) * 3);
      chk(idle_o === 1'b0, "R9 idle raised once", 32'(idle_o), 0);
    end

    // R10 disabled receiver ignores the line and keeps its state
    set_rate(160, 160, 1'b0);
    w1 = 9'h05A;
    send(w1, 1'b0, 1'b1, -1);
    en_i = 1'b0;
    hold(4);
    send(9'h0FF & ~w1, 1'b0, 1'b1, -1);
    chk(ready_o === 1'b1 && ovr_o === 1'b0, "R10 flags kept, no overrun while disabled",
        {30'd0, ready_o, ovr_o}, 2);
    chk(data_o === exp_word(w1, 1'b0), "R10 word kept while disabled", 32'(data_o), 32'(exp_word(w1, 1'b0)));
    do_read();
    send(9'h033, 1'b0, 1'b1, -1);
    chk(ready_o === 1'b0, "R10 no word while disabled", 32'(ready_o), 0);
    en_i = 1'b1;
    hold(2 * bitclk);
    plain_frames(1, 1'b0, "R10 re-enabled");

    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule